// File: doc/BRIEF.md
# Two-wire control register slave

This block gives a host controller access to a small bank of 8-bit control registers over a two-wire I2C bus. The registers hold settings for a picture-in-picture path, such as enables, window size, window position, freeze and picture adjustments. The meaning of the individual bits belongs to the logic that reads the register outputs. The bus inputs are brought into the system clock domain with two flip-flops. The slave then finds start and stop conditions from the sampled line levels and answers to one fixed pair of device address bytes: 24h to write and 25h to read.

A write transfer carries the device byte, then a sub-address, then any number of data bytes. These land in consecutive registers. A read takes two transfers. The first is a write transfer that carries only the sub-address and then ends. The second begins with a fresh start, or a repeated start, and the read byte. The slave then shifts out register contents and moves to the next register each time the host acknowledges. The slave pulls SDA low through an open-drain enable. A second output copies that enable so that a stronger external driver can be used on a heavily loaded data line.

Top module: `i2c_ctrl_regs`

## Requirements
- R1: After reset, every register reads 00h, sda_oe and ack_o are 0, and the slave waits for a start.
- R2: After a start, the slave acknowledges the byte 24h or 25h (7-bit device address 12h, R/W in bit 0). To acknowledge, it holds SDA low during the ninth SCL pulse.
- R3: Any other first byte after a start gets no acknowledge. The slave then leaves SDA alone and changes no register until the next start.
- R4: In a write transfer, the byte after the device byte is the sub-address. The next byte is stored in the register at that sub-address and is acknowledged.
- R5: Each further data byte in the same write transfer goes to the next register address. For example, three bytes sent to sub-address 04h land in 04h, 05h and 06h.
- R6: A data byte aimed at a sub-address of NREGS or above (16 by default) is neither stored nor acknowledged, and the address does not advance.
- R7: After a read byte, the slave drives the register at the current address MSB first. It moves to the next address after each byte. An address of NREGS or above reads as 00h.
- R8: When the host does not acknowledge a read byte, the slave releases SDA. It stays released, even under further SCL pulses, until the next start.
- R9: The slave releases its acknowledge at the SCL falling edge that ends the ninth pulse. An extra SCL pulse sent after the final acknowledge and before the stop changes no register.
- R10: A stop or a repeated start in the middle of a byte discards that byte. Registers written earlier in the transfer keep their values.
- R11: ack_o equals sda_oe whenever the host samples the acknowledge.
- R12: sda_oe changes only while SCL is low, except when reset forces it low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | When 1, pull SDA low |
| ack_o | output | 1 | Copy of the pull-down, for an external strong driver |
| regs_o | output | NREGS*8 | Register bank; register k occupies bits 8k+7 to 8k |

## Verification
The assertions assume that the SCL high and low phases each last several system clocks. They also assume that SDA never changes within a few clocks of an SCL edge, so the synchronised edges cannot be mistaken for start or stop conditions. The bench moves SCL and SDA at quarter-bit points of several clocks each and models SDA as a wired-AND of the host and the slave. A start or stop therefore cannot appear while the slave holds the line low. Random write and read transfers cover sub-addresses on both sides of the bank boundary and lengths of one to four bytes. Directed cases cover an unknown address, a host NACK, an aborted byte and the extra pulse after the last acknowledge.

// File: rtl/i2c_ctrl_regs.sv
module i2c_ctrl_regs #(
  parameter int NREGS = 16,
  parameter logic [6:0] DEV = 7'h12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic               ack_o,
  output logic [NREGS*8-1:0] regs_o
);
  localparam int AW = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam logic [8:0] LIMIT = 9'(NREGS);

  typedef enum logic [2:0] {IDLE, ADDR, SUB, WDATA, RDATA, IGNORE} st_t;

  st_t        st;
  logic [2:0] scl_q, sda_q;
  logic [3:0] cnt;
  logic [7:0] sh, tx, ptr;
  logic       mack;
  logic [7:0] regs [NREGS];

  wire scl_s = scl_q[1];
  wire sda_s = sda_q[1];
  wire scl_rise = scl_q[1] & ~scl_q[2];
  wire scl_fall = ~scl_q[1] & scl_q[2];
  wire start = scl_s & scl_q[2] & ~sda_q[1] & sda_q[2];
  wire stop  = scl_s & scl_q[2] & sda_q[1] & ~sda_q[2];
  wire in_rng = {1'b0, ptr} < LIMIT;
  wire [7:0] rd = in_rng ? regs[ptr[AW-1:0]] : 8'h00;

  assign ack_o = sda_oe;

  for (genvar k = 0; k < NREGS; k++) begin : g_out
    assign regs_o[k*8 +: 8] = regs[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      st <= IDLE;
      cnt <= '0;
      sh <= '0;
      tx <= '0;
      ptr <= '0;
      mack <= 1'b0;
      sda_oe <= 1'b0;
      for (int k = 0; k < NREGS; k++) regs[k] <= '0;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
      if (start) begin
        st <= ADDR;
        cnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop) begin
        st <= IDLE;
        cnt <= '0;
        sda_oe <= 1'b0;
      end else if (st != IDLE && st != IGNORE) begin
        if (scl_rise) begin
          if (cnt < 4'd8) begin
            sh <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (cnt == 4'd8) begin
            mack <= ~sda_s;
            cnt <= 4'd9;
          end
        end else if (scl_fall) begin
          if (cnt == 4'd8) begin
            case (st)
              ADDR: begin
                if (sh == {DEV, 1'b0}) begin st <= SUB; sda_oe <= 1'b1; end
                else if (sh == {DEV, 1'b1}) begin st <= RDATA; sda_oe <= 1'b1; end
                else st <= IGNORE;
              end
              SUB: begin
                ptr <= sh;
                st <= WDATA;
                sda_oe <= 1'b1;
              end
              WDATA: begin
                if (in_rng) begin
                  regs[ptr[AW-1:0]] <= sh;
                  ptr <= ptr + 8'd1;
                  sda_oe <= 1'b1;
                end
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (cnt == 4'd9) begin
            sda_oe <= 1'b0;
            cnt <= '0;
            if (st == RDATA) begin
              if (mack) begin
                tx <= rd;
                ptr <= ptr + 8'd1;
                sda_oe <= ~rd[7];
              end else begin
                st <= IGNORE;
              end
            end
          end else if (st == RDATA && cnt != 4'd0) begin
            tx <= {tx[6:0], 1'b0};
            sda_oe <= ~tx[6];
          end
        end
      end
    end
  end

  p_oe_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  p_regs_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> $past(scl_fall));

  p_write_acked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> sda_oe);

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE || st == IGNORE) |-> !sda_oe);

  p_nack_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RDATA && scl_fall && cnt == 4'd9 && !mack && !start && !stop) |=> !sda_oe);
endmodule

// File: tb/i2c_ctrl_regs_tb.sv
module i2c_ctrl_regs_tb_top;
  localparam int NR = 16;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic msda = 1'b1;
  logic sda_oe, ack_o;
  logic [NR*8-1:0] regs_o;
  wire line = msda & ~sda_oe;

  int checks = 0;
  int errors = 0;
  int hi_changes = 0;
  logic [7:0] expr [NR];
  logic [7:0] wbuf [8];
  logic prev_oe = 1'b0;

  always #2.5 clk = ~clk;

  i2c_ctrl_regs #(.NREGS(NR)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line),
    .sda_oe(sda_oe), .ack_o(ack_o), .regs_o(regs_o));

  always @(negedge clk) begin
    if (rst_n && scl && prev_oe !== sda_oe) hi_changes++;
    prev_oe = sda_oe;
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    msda = 1'b1; wq(Q); scl = 1'b1; wq(Q); msda = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop();
    msda = 1'b0; wq(Q); scl = 1'b1; wq(Q); msda = 1'b1; wq(Q);
  endtask

  task automatic send_bit(input logic b);
    msda = b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    msda = 1'b1; wq(Q); scl = 1'b1; wq(Q);
    acked = ~line;
    chk(ack_o === sda_oe, "R11 ack_o mirror", ack_o, sda_oe);
    wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input logic host_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      msda = 1'b1; wq(Q); scl = 1'b1; wq(Q);
      b[i] = line;
      wq(Q); scl = 1'b0; wq(Q);
    end
    msda = ~host_ack; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
    msda = 1'b1;
  endtask

  function automatic logic [7:0] rv(input int i);
    return regs_o[i*8 +: 8];
  endfunction

  task automatic cmp_all(input string tag);
    for (int i = 0; i < NR; i++) chk(rv(i) === expr[i], tag, rv(i), expr[i]);
  endtask

  task automatic wr_txn(input int sub, input int n);
    logic a;
    int p;
    p = sub;
    i2c_start();
    send_byte(8'h24, a); chk(a, "R2 write address ack", a, 1);
    send_byte(8'(sub), a); chk(a, "R4 sub-address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], a);
      if (p < NR) begin
        chk(a, "R5 data ack", a, 1);
        expr[p] = wbuf[k];
        p++;
      end else begin
        chk(!a, "R6 out-of-range no ack", a, 0);
      end
    end
    i2c_stop();
    cmp_all("R5 register contents");
  endtask

  task automatic rd_txn(input int sub, input int n, input logic rstart);
    logic a;
    logic [7:0] b, e;
    int p;
    p = sub;
    i2c_start();
    send_byte(8'h24, a);
    send_byte(8'(sub), a);
    if (!rstart) i2c_stop();
    i2c_start();
    send_byte(8'h25, a); chk(a, "R2 read address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      e = (p < NR) ? expr[p] : 8'h00;
      chk(b === e, "R7 read data", b, e);
      p++;
    end
    i2c_stop();
  endtask

  initial begin
    logic a;
    logic [7:0] b;
    void'($urandom(32'd1234));
    for (int i = 0; i < NR; i++) expr[i] = 8'h00;
    wq(4);
    chk(sda_oe === 1'b0 && ack_o === 1'b0, "R1 reset outputs", sda_oe, 0);
    rst_n = 1'b1;
    wq(4);
    cmp_all("R1 reset registers");

    wbuf[0] = 8'hFF; wbuf[1] = 8'h80; wbuf[2] = 8'hEE;
    wr_txn(4, 3);
    chk(rv(4) === 8'hFF && rv(5) === 8'h80 && rv(6) === 8'hEE, "R5 burst at 04h", rv(5), 8'h80);

    i2c_start();
    send_byte(8'h30, a); chk(!a, "R3 foreign address no ack", a, 0);
    send_byte(8'h02, a); chk(!a, "R3 later byte ignored", a, 0);
    send_byte(8'h5A, a); chk(!a, "R3 later byte ignored", a, 0);
    i2c_stop();
    cmp_all("R3 registers unchanged");

    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr_txn(NR - 1, 3);
    wr_txn(NR + 2, 1);

    rd_txn(4, 3, 1'b0);
    rd_txn(NR - 2, 3, 1'b1);

    i2c_start();
    send_byte(8'h24, a); send_byte(8'h04, a); i2c_stop();
    i2c_start(); send_byte(8'h25, a);
    recv_byte(1'b0, b);
    chk(b === expr[4], "R8 byte before NACK", b, expr[4]);
    recv_byte(1'b1, b);
    chk(b === 8'hFF, "R8 released after NACK", b, 8'hFF);
    chk(sda_oe === 1'b0, "R8 no drive after NACK", sda_oe, 0);
    i2c_stop();

    i2c_start();
    send_byte(8'h24, a); send_byte(8'h02, a);
    send_byte(8'hA5, a); expr[2] = 8'hA5;
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    i2c_stop();
    cmp_all("R10 abort by stop");
    i2c_start();
    send_byte(8'h24, a); send_byte(8'h08, a);
    send_byte(8'h3C, a); expr[8] = 8'h3C;
    send_bit(1'b1); send_bit(1'b1);
    i2c_start();
    send_byte(8'h24, a); chk(a, "R10 repeated start re-addresses", a, 1);
    i2c_stop();
    cmp_all("R10 abort by repeated start");

    i2c_start();
    send_byte(8'h24, a); send_byte(8'h0A, a);
    send_byte(8'h77, a); expr[10] = 8'h77;
    msda = 1'b1; wq(Q); scl = 1'b1; wq(Q);
    chk(line === 1'b1 && sda_oe === 1'b0, "R9 drive released in extra pulse", sda_oe, 0);
    wq(Q); scl = 1'b0; wq(Q);
    i2c_stop();
    cmp_all("R9 extra pulse harmless");

    for (int t = 0; t < 24; t++) begin
      int sub, n;
      sub = int'($urandom_range(NR + 3, 0));
      n = int'($urandom_range(4, 1));
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom());
      wr_txn(sub, n);
    end
    for (int t = 0; t < 10; t++)
      rd_txn(int'($urandom_range(NR + 1, 0)), int'($urandom_range(4, 1)), t[0]);

    chk(hi_changes == 0, "R12 sda_oe changed with SCL high", hi_changes, 0);

    rst_n = 1'b0; wq(2);
    for (int i = 0; i < NR; i++) expr[i] = 8'h00;
    cmp_all("R1 reset clears bank");
    rst_n = 1'b1; wq(2);

    summary();
    $finish;
  end
endmodule